// File: doc/BRIEF.md
# Pixel Word Unpacker

This block sits between a pixel FIFO and a parallel display data bus. Each cycle it either takes a 32-bit memory word from a valid/ready stream or sends out one pixel on the display bus. When the bus is in pixel-clock mode, the bus emits one pixel per cycle.

Two settings control how a word is split. The first is a word-length code: 16-bit pixels are RGB565, packed two per word. 32-bit pixels carry 8 bits each of red, green and blue, and the top byte is discarded. The second is a byte-valid mask, which must match the word length. A bus-width code selects an 8, 16, 18 or 24-bit display bus. The block then narrows, widens or splits each pixel to fit that bus.

Some settings cannot be served. In that case the block raises an error flag, emits nothing and drains incoming words until it is given a legal setting.

Top module: `pix_word_unpacker`

## Requirements
- R1: After reset, `pix_valid` and `cfg_error` are 0 and `in_ready` is 1.
- R2: Word-length code 0 with mask 0xF on a 16-bit bus (bus code 0) emits two pixels per word on consecutive cycles:
  - the first pixel is bits 15:0 and the second is bits 31:16;
  - each pixel appears on `pix_data[15:0]` and `pix_data[23:16]` is 0;
  - the first pixel is valid in the cycle after the word is accepted.
- R3: Word-length code 3 with mask 0x7 on a 24-bit bus (bus code 3) emits one pixel per word, `pix_data` = word bits 23:0. Word bits 31:24 have no effect.
- R4: Word-length code 3 on an 18-bit bus (bus code 2) emits `pix_data[17:0]` = {red[7:2], green[7:2], blue[7:2]}, with red at word bits 23:16, green at 15:8 and blue at 7:0. Bits 23:18 are 0.
- R5: Word-length code 3 on a 16-bit bus emits `pix_data[15:0]` = {red[7:3], green[7:2], blue[7:3]}, with bits 23:16 at 0.
- R6: An RGB565 pixel (red 15:11, green 10:5, blue 4:0) is widened by repeating the top bits of each channel:
  - on the 18-bit bus, each channel becomes 6 bits in `pix_data[17:0]`, upper bits 0;
  - on the 24-bit bus, each channel becomes 8 bits across `pix_data[23:0]`.
- R7: Word-length code 0 on an 8-bit bus (bus code 1) emits four bytes per word on `pix_data[7:0]`, upper bits 0, in the order word bits 7:0, 15:8, 23:16, 31:24.
- R8: The configuration is illegal when any of these holds:
  - the word-length code is 1 or 2;
  - the mask does not match the word length;
  - word length 3 is set with the 8-bit bus.

  `cfg_error` is 1 from the cycle after an illegal setting appears. While it is set, no pixel is emitted, `in_ready` is 1 and accepted words are discarded.
- R9: `cfg_error` returns to 0 in the cycle after a legal setting is applied. Words sent afterwards are unpacked normally.
- R10: `in_ready` is 0 while the word being emitted still has beats left after the current one. It is 1 on the last beat, so words sent back to back give an unbroken run of valid pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input memory word |
| in_ready | output | 1 | Block accepts a word this cycle |
| cfg_word_len | input | 2 | Word-length code: 0 = two RGB565 pixels per word, 3 = one 8:8:8 pixel per word |
| cfg_bus_width | input | 2 | Bus code: 0 = 16-bit, 1 = 8-bit, 2 = 18-bit, 3 = 24-bit |
| cfg_byte_mask | input | 4 | Valid-byte mask, must be 0xF for code 0 and 0x7 for code 3 |
| pix_valid | output | 1 | A pixel or bus beat is present on `pix_data` |
| pix_data | output | 24 | Display bus data, unused upper bits 0 |
| cfg_error | output | 1 | Illegal configuration flag |

## Verification
The bench targets four classes of fault, and each has a visible symptom:
- **Halfword and byte order.** A design that swaps the order emits the two pixels of a word, or the four bytes on the 8-bit bus, reversed.
- **Channel reduction.** A design that takes the low bits of a channel instead of the high ones, or pads zeros where it should repeat the top bits, produces wrong colours on the 16, 18 and 24-bit buses. The test words are chosen to expose both mistakes.
- **Back-to-back timing.** A ready signal that rises one beat late leaves gaps between words. One that rises early loses the second pixel of a word.
- **Illegal configurations.** Each illegal form is applied in turn. A design that still emits pixels, stalls the stream, or keeps its flag after a legal setting returns is caught.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int HALF_W = WORD_W / 2;
  localparam int BEAT_W = 2;
  localparam int CNT_W  = BEAT_W + 1;

  localparam logic [1:0] WL_PACKED = 2'd0;
  localparam logic [1:0] WL_SINGLE = 2'd3;
  localparam logic [1:0] BUS_16    = 2'd0;
  localparam logic [1:0] BUS_8     = 2'd1;
  localparam logic [1:0] BUS_18    = 2'd2;
  localparam logic [1:0] BUS_24    = 2'd3;
  localparam logic [3:0] MASK_PACKED = 4'hF;
  localparam logic [3:0] MASK_SINGLE = 4'h7;

  function automatic logic cfg_is_legal(input logic [1:0] wl, input logic [1:0] bw,
                                        input logic [3:0] mask);
    logic ok_packed, ok_single;
    ok_packed = (wl == WL_PACKED) && (mask == MASK_PACKED);
    ok_single = (wl == WL_SINGLE) && (mask == MASK_SINGLE) && (bw != BUS_8);
    return ok_packed || ok_single;
  endfunction

  function automatic logic [CNT_W-1:0] beats_for(input logic [1:0] wl, input logic [1:0] bw);
    if (wl == WL_SINGLE) return CNT_W'(1);
    else if (bw == BUS_8) return CNT_W'(4);
    else return CNT_W'(2);
  endfunction

  function automatic logic [PIX_W-1:0] widen_565(input logic [HALF_W-1:0] hw,
                                                 input logic [1:0] bw);
    logic [4:0] r, b;
    logic [5:0] g;
    r = hw[15:11];
    g = hw[10:5];
    b = hw[4:0];
    case (bw)
      BUS_18:  return {6'd0, r, r[4], g, b, b[4]};
      BUS_24:  return {r, r[4:2], g, g[5:4], b, b[4:2]};
      default: return {8'd0, hw};
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] narrow_888(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] bw);
    logic [7:0] r, g, b;
    r = w[23:16];
    g = w[15:8];
    b = w[7:0];
    case (bw)
      BUS_24:  return {r, g, b};
      BUS_18:  return {6'd0, r[7:2], g[7:2], b[7:2]};
      default: return {8'd0, r[7:3], g[7:2], b[7:3]};
    endcase
  endfunction
endpackage

// File: rtl/pwu_cfg_guard.sv
module pwu_cfg_guard
  import pwu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wl,
  input  logic [1:0] bw,
  input  logic [3:0] mask,
  output logic       illegal_now,
  output logic       err_q
);
  assign illegal_now = !cfg_is_legal(wl, bw, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal_now;
  end
endmodule

// File: rtl/pwu_beat_seq.sv
module pwu_beat_seq
  import pwu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              drop,
  input  logic [1:0]        wl,
  input  logic [1:0]        bw,
  output logic [WORD_W-1:0] word_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic [1:0]        wl_q,
  output logic [1:0]        bw_q,
  output logic              busy,
  output logic              last_beat,
  output logic              accept_evt
);
  logic [CNT_W-1:0] nbeats_q;

  assign last_beat  = busy && ({1'b0, beat_q} == (nbeats_q - CNT_W'(1)));
  assign in_ready   = !busy || last_beat || drop;
  assign accept_evt = in_valid && in_ready && !drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat_q   <= '0;
      nbeats_q <= CNT_W'(1);
      word_q   <= '0;
      wl_q     <= WL_PACKED;
      bw_q     <= BUS_16;
    end else if (drop) begin
      busy   <= 1'b0;
      beat_q <= '0;
    end else if (accept_evt) begin
      busy     <= 1'b1;
      beat_q   <= '0;
      nbeats_q <= beats_for(wl, bw);
      word_q   <= in_data;
      wl_q     <= wl;
      bw_q     <= bw;
    end else if (busy) begin
      if (last_beat) busy <= 1'b0;
      else           beat_q <= beat_q + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/pwu_bus_format.sv
module pwu_bus_format
  import pwu_pkg::*;
(
  input  logic [WORD_W-1:0] word_q,
  input  logic [BEAT_W-1:0] beat_q,
  input  logic [1:0]        wl_q,
  input  logic [1:0]        bw_q,
  output logic [PIX_W-1:0]  pix
);
  logic [HALF_W-1:0] hw_sel;
  logic [7:0]        byte_sel;

  always_comb begin
    if (bw_q == BUS_8) hw_sel = beat_q[1] ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
    else               hw_sel = beat_q[0] ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
    byte_sel = beat_q[0] ? hw_sel[15:8] : hw_sel[7:0];

    if (wl_q == WL_SINGLE)  pix = narrow_888(word_q, bw_q);
    else if (bw_q == BUS_8) pix = {16'd0, byte_sel};
    else                    pix = widen_565(hw_sel, bw_q);
  end
endmodule

// File: rtl/pix_word_unpacker.sv
module pix_word_unpacker
  import pwu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        cfg_word_len,
  input  logic [1:0]        cfg_bus_width,
  input  logic [3:0]        cfg_byte_mask,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              cfg_error
);
  logic              illegal_now;
  logic              drop_now;
  logic [WORD_W-1:0] word_q;
  logic [BEAT_W-1:0] beat_q;
  logic [1:0]        wl_q;
  logic [1:0]        bw_q;
  logic              busy;
  logic              last_beat;
  logic              accept_evt;

  pwu_cfg_guard u_guard (
    .clk(clk), .rst_n(rst_n),
    .wl(cfg_word_len), .bw(cfg_bus_width), .mask(cfg_byte_mask),
    .illegal_now(illegal_now), .err_q(cfg_error)
  );

  assign drop_now = illegal_now || cfg_error;

  pwu_beat_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .drop(drop_now), .wl(cfg_word_len), .bw(cfg_bus_width),
    .word_q(word_q), .beat_q(beat_q), .wl_q(wl_q), .bw_q(bw_q),
    .busy(busy), .last_beat(last_beat), .accept_evt(accept_evt)
  );

  pwu_bus_format u_fmt (
    .word_q(word_q), .beat_q(beat_q), .wl_q(wl_q), .bw_q(bw_q),
    .pix(pix_data)
  );

  assign pix_valid = busy;
endmodule

// File: rtl/pwu_checker.sv
module pwu_checker
  import pwu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             cfg_error,
  input logic             accept_evt,
  input logic             last_beat,
  input logic             illegal_now,
  input logic [1:0]       bw_q
);
  AST_ERR_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !pix_valid); // R8
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_now |=> cfg_error); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_error && !illegal_now) |=> !cfg_error); // R9
  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !illegal_now) |=> pix_valid); // R2
  AST_HOLD_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !last_beat && !illegal_now && !cfg_error) |-> !in_ready); // R10
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> in_ready); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bw_q == BUS_16) |-> (pix_data[23:16] == 8'd0)); // R5
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bw_q == BUS_8) |-> (pix_data[23:8] == 16'd0)); // R7
endmodule

bind pix_word_unpacker pwu_checker u_chk (.*);

// File: tb/sim_pix_word_unpacker.sv
module sim_pix_word_unpacker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [1:0]  cfg_word_len = 2'd0;
  logic [1:0]  cfg_bus_width = 2'd0;
  logic [3:0]  cfg_byte_mask = 4'hF;
  logic        pix_valid;
  logic [23:0] pix_data;
  logic        cfg_error;

  int n_tests = 0;
  int n_fail  = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_word_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_word_len(cfg_word_len), .cfg_bus_width(cfg_bus_width),
    .cfg_byte_mask(cfg_byte_mask), .pix_valid(pix_valid), .pix_data(pix_data),
    .cfg_error(cfg_error)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] rep6(input logic [15:0] h);
    int r, g, b;
    r = (h >> 11) & 31; g = (h >> 5) & 63; b = h & 31;
    r = (r << 1) | (r >> 4); b = (b << 1) | (b >> 4);
    return 24'((r << 12) | (g << 6) | b);
  endfunction

  function automatic logic [23:0] rep8(input logic [15:0] h);
    int r, g, b;
    r = (h >> 11) & 31; g = (h >> 5) & 63; b = h & 31;
    r = (r << 3) | (r >> 2); g = (g << 2) | (g >> 4); b = (b << 3) | (b >> 2);
    return 24'((r << 16) | (g << 8) | b);
  endfunction

  task automatic push_exp(input logic [23:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic push_word(input logic [31:0] w);
    int r, g, b;
    if (cfg_word_len == 2'd0) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] h;
        h = (k == 0) ? w[15:0] : w[31:16];
        case (cfg_bus_width)
          2'd1: begin
            push_exp({16'd0, h[7:0]}, "R7");
            push_exp({16'd0, h[15:8]}, "R7");
          end
          2'd0: push_exp({8'd0, h}, "R2");
          2'd2: push_exp(rep6(h), "R6");
          default: push_exp(rep8(h), "R6");
        endcase
      end
    end else begin
      r = int'(w[23:16]); g = int'(w[15:8]); b = int'(w[7:0]);
      case (cfg_bus_width)
        2'd3: push_exp(24'((r << 16) | (g << 8) | b), "R3");
        2'd2: push_exp(24'(((r >> 2) << 12) | ((g >> 2) << 6) | (b >> 2)), "R4");
        default: push_exp(24'(((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3)), "R5");
      endcase
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    push_word(w);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R10 idle after drain", {31'd0, pix_valid}, 32'd0);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m);
    @(negedge clk);
    cfg_word_len = wl; cfg_bus_width = bw; cfg_byte_mask = m;
  endtask

  task automatic illegal_case(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m);
    set_cfg(wl, bw, m);
    @(negedge clk);
    check("R8 flag raised", {31'd0, cfg_error}, 32'd1);
    check("R8 ready while illegal", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 flag sticky", {31'd0, cfg_error}, 32'd1);
    check("R8 no pixel", {31'd0, pix_valid}, 32'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8 unexpected pixel actual=%h expected=none", pix_data);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {8'd0, pix_data}, {8'd0, e});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pix_valid", {31'd0, pix_valid}, 32'd0);
    check("R1 cfg_error", {31'd0, cfg_error}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);

    // R2, R10: packed on 16-bit bus, back to back
    send(32'h1234_ABCD); send(32'hF00F_0FF0); send(32'h8001_7FFE); idle(); drain();

    // R10: ready low on first beat, high on last
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h5555_AAAA;
    @(posedge clk); push_word(32'h5555_AAAA);
    @(negedge clk); in_valid = 1'b0;
    check("R10 ready low mid-word", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R10 ready high last beat", {31'd0, in_ready}, 32'd1);
    drain();

    // R6: widened 565
    set_cfg(2'd0, 2'd2, 4'hF); send(32'h8410_F81F); send(32'h07E0_001F); idle(); drain();
    set_cfg(2'd0, 2'd3, 4'hF); send(32'h8410_F81F); send(32'hFFFF_0821); idle(); drain();
    // R7: byte beats
    set_cfg(2'd0, 2'd1, 4'hF); send(32'h4433_2211); send(32'hDDCC_BBAA); idle(); drain();
    // R3, R4, R5: single pixel words, top byte set
    set_cfg(2'd3, 2'd3, 4'h7); send(32'hFF12_3456); send(32'hA5C3_81E7); idle(); drain();
    set_cfg(2'd3, 2'd2, 4'h7); send(32'h77FC_0383); send(32'h0081_7E41); idle(); drain();
    set_cfg(2'd3, 2'd0, 4'h7); send(32'h99F8_FC1F); send(32'h0047_A3C9); idle(); drain();

    // R8 illegal forms, R9 recovery
    illegal_case(2'd1, 2'd0, 4'hF);
    illegal_case(2'd0, 2'd0, 4'h7);
    illegal_case(2'd3, 2'd1, 4'h7);
    illegal_case(2'd3, 2'd3, 4'hF);
    set_cfg(2'd0, 2'd0, 4'hF);
    @(negedge clk);
    check("R9 flag cleared", {31'd0, cfg_error}, 32'd0);
    send(32'hCAFE_BABE); idle(); drain();
    check("R9 scoreboard empty", exp_q.size(), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule